// File: doc/BRIEF.md
# Streaming Perceptron Inference Engine

This block runs inference for a small fixed-shape perceptron network: seven input features, one hidden layer of two neurons with a sigmoid activation, and one output neuron with a linear activation. All values are unsigned bytes in 0.8 fixed point, so a byte `b` stands for `b/256`. The block has no built-in weights. Each transaction on the input byte stream first delivers a full weight set and then a chunk of 64 samples. A different trained network therefore runs on the same hardware without any change to the logic.

For every sample the block accumulates both hidden pre-activations as the feature bytes arrive. It then passes each one through a 256-entry sigmoid table that is computed at elaboration. The output neuron combines the two activations with its own weights, and the block returns one result byte per sample on an output stream. The output stream marks the last result of a chunk. Both streams follow the usual valid/ready handshake. The block stalls its input while a result is waiting to be accepted, so no result is ever dropped. A feature that a network does not use simply gets zero weights. Software splits a larger data set into 64-sample chunks.

Top module: `mlp_stream_accel`

## Requirements
- R1: After reset, `m_tvalid` and `m_tlast` are 0 and `s_tready` is 1, so the block is ready for the first weight byte.
- R2: The first 16 accepted bytes of a transaction are the hidden weights, neuron 0 first. Within each neuron the bias weight comes first, then the weights of features 1 to 7. The next 3 bytes are the output weights: bias, then hidden neuron 0, then hidden neuron 1.
- R3: After the weights come 64 samples of 7 feature bytes each, sent sample after sample with the features in index order 1 to 7.
- R4: Hidden pre-activation p = floor((256*wb + sum of wi*xi)/256). When this value exceeds 255 it saturates to 255.
- R5: Hidden activation h = floor(256/(1+exp(-(6p/256-3))) + 0.5), clamped to 255. The table is non-decreasing in p.
- R6: Result = floor((256*vb + v0*h0 + v1*h1)/256), saturated to 255.
- R7: Exactly one result byte is produced per sample, in sample order. `m_tlast` is 1 only on the 64th result of a chunk.
- R8: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values, and no result is lost.
- R9: Gaps in `s_tvalid` (idle cycles between bytes) do not change any result.
- R10: After the 64th sample the next accepted byte is again the first hidden weight. A new weight set takes effect for the next chunk.
- R11: A feature whose weights are all zero has no effect on the result, whatever its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 8 | Input stream byte: a weight or a feature |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Block accepts an input byte |
| m_tdata | output | 8 | Result byte for one sample |
| m_tvalid | output | 1 | Result valid |
| m_tready | input | 1 | Downstream accepts the result |
| m_tlast | output | 1 | Marks the 64th result of a chunk |

## Verification
Four chunks are streamed, each with its own weight set. A mid-range weight set with ramp features tests the byte order and the sigmoid lookup. All-zero features leave only the bias terms, which shows whether the bias is aligned as 1.0. All-maximum weights and features push both the hidden and the output sums past 255, which separates saturation from wrap-around. A set with zero weights on feature 7, driven with random feature values, shows that an unused feature has no effect and that reloaded weights replace the old ones. Random idle cycles on the input and random ready drops on the output are mixed through all four chunks.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

  // Sigmoid sample for an index in [0, 2**dw): scale/(1+exp(-(6*idx/scale-3))),
  // rounded to nearest and clamped to the largest code.
  function automatic int sig_entry(input int idx, input int dw);
    real scale;
    real t;
    real y;
    int  r;
    scale = 2.0 ** dw;
    t     = 6.0 * idx / scale - 3.0;
    y     = scale / (1.0 + $exp(-t));
    r     = $rtoi($floor(y + 0.5));
    if (r > (1 << dw) - 1) r = (1 << dw) - 1;
    return r;
  endfunction

  typedef enum logic [2:0] {
    ST_LD_HID = 3'd0,
    ST_LD_OUT = 3'd1,
    ST_FEAT   = 3'd2,
    ST_SIG    = 3'd3,
    ST_EMIT   = 3'd4
  } accel_state_t;

endpackage

// File: rtl/mlp_hidden_neuron.sv
module mlp_hidden_neuron #(
  parameter int DW     = 8,
  parameter int N_FEAT = 7,
  localparam int WI_W  = $clog2(N_FEAT + 1),
  localparam int ACC_W = 2 * DW + WI_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          w_we,
  input  logic [WI_W-1:0] w_idx,
  input  logic [DW-1:0] w_data,
  input  logic          f_valid,
  input  logic [WI_W-1:0] f_idx,
  input  logic [DW-1:0] f_data,
  output logic [DW-1:0] pre
);

  logic [DW-1:0]    wgt [N_FEAT+1];
  logic [ACC_W-1:0] acc;
  logic [WI_W-1:0]  widx;
  logic [2*DW-1:0]  prod;
  logic [2*DW-1:0]  bias_sh;
  logic [ACC_W-DW-1:0] shifted;

  // weight file, no reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (w_we) wgt[w_idx] <= w_data;
  end

  assign widx    = f_idx + WI_W'(1);
  assign prod    = (2*DW)'(wgt[widx]) * (2*DW)'(f_data);
  assign bias_sh = {wgt[0], {DW{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (f_valid) begin
      if (f_idx == '0) acc <= ACC_W'(bias_sh) + ACC_W'(prod);
      else             acc <= acc + ACC_W'(prod);
    end
  end

  assign shifted = acc[ACC_W-1:DW];
  assign pre     = (|shifted[ACC_W-DW-1:DW]) ? {DW{1'b1}} : shifted[DW-1:0];

  // R4: partial sums of one sample only grow
  assert_acc_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
    (f_valid && f_idx != '0) |=> (acc >= $past(acc)));

endmodule

// File: rtl/mlp_sigmoid_rom.sv
module mlp_sigmoid_rom #(
  parameter int DW     = 8,
  parameter int N_PORT = 2,
  localparam int DEPTH = 1 << DW
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [N_PORT-1:0][DW-1:0]    addr,
  output logic [N_PORT-1:0][DW-1:0]    data
);

  logic [DW-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    assign table_q[g] = DW'(mlp_pkg::sig_entry(g, DW));
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int p = 0; p < N_PORT; p++) data[p] <= table_q[addr[p]];
    end
  end

  if (N_PORT >= 2) begin : g_mono_chk
    // R5: a larger index never reads a smaller activation
    assert_sig_monotonic_R5: assert property (@(posedge clk) disable iff (rst)
      ($past(rd_en) && ($past(addr[0]) <= $past(addr[1]))) |-> (data[0] <= data[1]));
  end

endmodule

// File: rtl/mlp_output_neuron.sv
module mlp_output_neuron #(
  parameter int DW    = 8,
  parameter int N_HID = 2,
  localparam int OI_W = $clog2(N_HID + 1),
  localparam int OA_W = 2 * DW + OI_W + 1
) (
  input  logic                      clk,
  input  logic                      w_we,
  input  logic [OI_W-1:0]           w_idx,
  input  logic [DW-1:0]             w_data,
  input  logic [N_HID-1:0][DW-1:0]  h,
  output logic [DW-1:0]             y
);

  logic [DW-1:0]   wgt [N_HID+1];
  logic [OA_W-1:0] sum;
  logic [OA_W-DW-1:0] shifted;

  always_ff @(posedge clk) begin
    if (w_we) wgt[w_idx] <= w_data;
  end

  always_comb begin
    sum = OA_W'({wgt[0], {DW{1'b0}}});
    for (int i = 0; i < N_HID; i++) begin
      sum = sum + OA_W'(OA_W'(wgt[i+1]) * OA_W'(h[i]));
    end
  end

  assign shifted = sum[OA_W-1:DW];
  assign y       = (|shifted[OA_W-DW-1:DW]) ? {DW{1'b1}} : shifted[DW-1:0];

endmodule

// File: rtl/mlp_stream_accel.sv
module mlp_stream_accel #(
  parameter int DW     = 8,
  parameter int N_FEAT = 7,
  parameter int N_HID  = 2,
  parameter int CHUNK  = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] s_tdata,
  input  logic          s_tvalid,
  output logic          s_tready,
  output logic [DW-1:0] m_tdata,
  output logic          m_tvalid,
  input  logic          m_tready,
  output logic          m_tlast
);
  import mlp_pkg::*;

  localparam int WI_W = $clog2(N_FEAT + 1);
  localparam int HN_W = (N_HID > 1) ? $clog2(N_HID) : 1;
  localparam int OI_W = $clog2(N_HID + 1);
  localparam int SC_W = (CHUNK > 1) ? $clog2(CHUNK) : 1;

  accel_state_t state;
  logic [WI_W-1:0] wi;
  logic [HN_W-1:0] wn;
  logic [OI_W-1:0] ow;
  logic [WI_W-1:0] fcnt;
  logic [SC_W-1:0] scnt;
  logic            acc_in;
  logic            slot_free;

  logic [N_HID-1:0][DW-1:0] pre;
  logic [N_HID-1:0][DW-1:0] act;
  logic [DW-1:0]            y;

  assign s_tready  = (state == ST_LD_HID) || (state == ST_LD_OUT) || (state == ST_FEAT);
  assign acc_in    = s_tvalid && s_tready;
  assign slot_free = !m_tvalid || m_tready;

  for (genvar g = 0; g < N_HID; g++) begin : g_hid
    mlp_hidden_neuron #(.DW(DW), .N_FEAT(N_FEAT)) u_hid (
      .clk     (clk),
      .rst     (rst),
      .w_we    (acc_in && (state == ST_LD_HID) && (wn == HN_W'(g))),
      .w_idx   (wi),
      .w_data  (s_tdata),
      .f_valid (acc_in && (state == ST_FEAT)),
      .f_idx   (fcnt),
      .f_data  (s_tdata),
      .pre     (pre[g])
    );
  end

  mlp_sigmoid_rom #(.DW(DW), .N_PORT(N_HID)) u_sig (
    .clk   (clk),
    .rst   (rst),
    .rd_en (state == ST_SIG),
    .addr  (pre),
    .data  (act)
  );

  mlp_output_neuron #(.DW(DW), .N_HID(N_HID)) u_out (
    .clk    (clk),
    .w_we   (acc_in && (state == ST_LD_OUT)),
    .w_idx  (ow),
    .w_data (s_tdata),
    .h      (act),
    .y      (y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LD_HID;
      wi       <= '0;
      wn       <= '0;
      ow       <= '0;
      fcnt     <= '0;
      scnt     <= '0;
      m_tdata  <= '0;
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
    end else begin
      if (m_tvalid && m_tready) begin
        m_tvalid <= 1'b0;
        m_tlast  <= 1'b0;
      end
      unique case (state)
        ST_LD_HID: if (acc_in) begin
          if (wi == WI_W'(N_FEAT)) begin
            wi <= '0;
            if (wn == HN_W'(N_HID - 1)) begin
              wn    <= '0;
              state <= ST_LD_OUT;
            end else begin
              wn <= wn + HN_W'(1);
            end
          end else begin
            wi <= wi + WI_W'(1);
          end
        end
        ST_LD_OUT: if (acc_in) begin
          if (ow == OI_W'(N_HID)) begin
            ow    <= '0;
            state <= ST_FEAT;
          end else begin
            ow <= ow + OI_W'(1);
          end
        end
        ST_FEAT: if (acc_in) begin
          if (fcnt == WI_W'(N_FEAT - 1)) begin
            fcnt  <= '0;
            state <= ST_SIG;
          end else begin
            fcnt <= fcnt + WI_W'(1);
          end
        end
        ST_SIG: state <= ST_EMIT;
        ST_EMIT: if (slot_free) begin
          m_tdata  <= y;
          m_tvalid <= 1'b1;
          m_tlast  <= (scnt == SC_W'(CHUNK - 1));
          if (scnt == SC_W'(CHUNK - 1)) begin
            scnt  <= '0;
            state <= ST_LD_HID;
          end else begin
            scnt  <= scnt + SC_W'(1);
            state <= ST_FEAT;
          end
        end
        default: state <= ST_LD_HID;
      endcase
    end
  end

  // R8: a stalled result is held unchanged
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // R7: the last flag lines up with the count of delivered results
  logic [SC_W-1:0] out_seen;
  always_ff @(posedge clk) begin
    if (rst) out_seen <= '0;
    else if (m_tvalid && m_tready)
      out_seen <= (out_seen == SC_W'(CHUNK - 1)) ? '0 : out_seen + SC_W'(1);
  end

  assert_last_pos_R7: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (m_tlast == (out_seen == SC_W'(CHUNK - 1))));

  // R10: once a chunk is finished, the next input byte is taken as a weight
  assert_reload_R10: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && m_tlast && m_tready) |-> (state == ST_LD_HID));

endmodule

// File: tb/tb_mlp_stream_accel.sv
module tb_mlp_stream_accel;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] s_tdata = '0;
  logic       s_tvalid = 1'b0;
  logic       s_tready;
  logic [7:0] m_tdata;
  logic       m_tvalid;
  logic       m_tready = 1'b0;
  logic       m_tlast;

  int checks = 0;
  int fails  = 0;
  int   exp_q[$];
  bit   last_q[$];
  string tag_q[$];
  bit   done = 1'b0;

  int wh[2][8];
  int wo[3];
  int xs[64][7];

  always #5 clk = ~clk;

  mlp_stream_accel dut (
    .clk(clk), .rst(rst),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  function automatic int sig_ref(input int p);
    real y;
    int r;
    y = 256.0 / (1.0 + $exp(-(6.0 * p / 256.0 - 3.0)));
    r = $rtoi($floor(y + 0.5));
    return (r > 255) ? 255 : r;
  endfunction

  function automatic int model(input int s);
    int h[2];
    int acc;
    for (int n = 0; n < 2; n++) begin
      acc = wh[n][0] * 256;
      for (int f = 0; f < 7; f++) acc += wh[n][f+1] * xs[s][f];
      acc = acc / 256;
      if (acc > 255) acc = 255;
      h[n] = sig_ref(acc);
    end
    acc = (wo[0] * 256 + wo[1] * h[0] + wo[2] * h[1]) / 256;
    return (acc > 255) ? 255 : acc;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send_byte(input int b);
    @(negedge clk);
    if ($urandom_range(0, 3) == 0) begin
      s_tvalid = 1'b0;                 // R9: idle gap
      @(negedge clk);
    end
    s_tvalid = 1'b1;
    s_tdata  = 8'(b);
    while (!s_tready) @(negedge clk);
    @(posedge clk);
    #1 s_tvalid = 1'b0;
  endtask

  task automatic send_chunk(input string tag);
    for (int s = 0; s < 64; s++) begin
      exp_q.push_back(model(s));
      last_q.push_back(s == 63);
      tag_q.push_back(tag);
    end
    for (int n = 0; n < 2; n++)
      for (int j = 0; j < 8; j++) send_byte(wh[n][j]);   // R2
    for (int j = 0; j < 3; j++) send_byte(wo[j]);
    for (int s = 0; s < 64; s++)
      for (int f = 0; f < 7; f++) send_byte(xs[s][f]);   // R3
  endtask

  // monitor / scoreboard
  initial begin : monitor
    bit   held = 1'b0;
    int   hd = 0;
    bit   hl = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (held) check(m_tvalid && m_tdata == 8'(hd) && m_tlast == hl,
                        "R8 hold", int'(m_tdata), hd);
        m_tready = ($urandom_range(0, 9) < 6);
        held = 1'b0;
        if (m_tvalid && m_tready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 extra result", int'(m_tdata), -1);
          end else begin
            int e;
            bit l;
            string t;
            e = exp_q.pop_front();
            l = last_q.pop_front();
            t = tag_q.pop_front();
            check(m_tdata == 8'(e), t, int'(m_tdata), e);
            check(m_tlast == l, "R7 last flag", int'(m_tlast), int'(l));
          end
        end else if (m_tvalid) begin
          held = 1'b1;
          hd = int'(m_tdata);
          hl = m_tlast;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(m_tvalid == 1'b0, "R1 valid after reset", int'(m_tvalid), 0);
    check(m_tlast  == 1'b0, "R1 last after reset",  int'(m_tlast), 0);
    check(s_tready == 1'b1, "R1 ready after reset", int'(s_tready), 1);

    // chunk A: mid-range weights, ramp features (R4 R5 R6)
    for (int n = 0; n < 2; n++)
      for (int j = 0; j < 8; j++) wh[n][j] = (j * 13 + n * 29 + 5) % 40;
    wo = '{30, 120, 90};
    for (int s = 0; s < 64; s++)
      for (int f = 0; f < 7; f++) xs[s][f] = (s * 4 + f * 9) % 256;
    send_chunk("R4 R5 R6 ramp");

    // chunk B: zero features, bias only (R4 R6 R10 new weights)
    wh[0] = '{100, 9, 9, 9, 9, 9, 9, 9};
    wh[1] = '{200, 7, 7, 7, 7, 7, 7, 7};
    wo = '{10, 200, 50};
    for (int s = 0; s < 64; s++)
      for (int f = 0; f < 7; f++) xs[s][f] = 0;
    send_chunk("R4 R10 bias only");

    // chunk C: saturation of hidden and output sums (R4 R6)
    for (int n = 0; n < 2; n++)
      for (int j = 0; j < 8; j++) wh[n][j] = 255;
    wo = '{255, 255, 255};
    for (int s = 0; s < 64; s++)
      for (int f = 0; f < 7; f++) xs[s][f] = (s < 32) ? 255 : s;
    send_chunk("R6 saturation");

    // chunk D: feature 7 weights zero, feature 7 random (R11)
    for (int n = 0; n < 2; n++)
      for (int j = 0; j < 7; j++) wh[n][j] = (j * 7 + n * 11 + 3) % 36;
    wh[0][7] = 0;
    wh[1][7] = 0;
    wo = '{5, 140, 110};
    for (int s = 0; s < 64; s++)
      for (int f = 0; f < 7; f++)
        xs[s][f] = (f == 6) ? int'($urandom_range(0, 255)) : (s * 3 + f * 17) % 200;
    send_chunk("R11 unused feature");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(m_tvalid == 1'b0, "R7 no extra result", int'(m_tvalid), 0);
    check(s_tready == 1'b1, "R10 ready for weights", int'(s_tready), 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule